// File: doc/BRIEF.md
# Timestamp Capture FIFO Readout

This block holds captured precision-time event timestamps for several network ports, in two directions per port (transmit and receive), and lets a host drain them through a small register window. A capture source hands the block one complete record per cycle. The record holds:

- a message tag,
- a 48-bit seconds value,
- a 32-bit nanoseconds value,
- a 64-bit source clock identity,
- a source port number,
- a sequence number.

Each direction of each port queues its records in its own FIFO. The host reads the records back as a fixed series of 16-bit words from one data register per channel.

Each channel has a status register. It carries the capture enable, the position of the host within the current record, and a saturating count of captures lost because the FIFO was full. A global register reports which channels hold data. An interrupt mask selects which of those channels raise the single interrupt output.

The register bus is a simple read/write strobe interface. Read data is registered and appears one cycle after the read strobe.

Top module: `ts_capture_readout`

## Requirements
- R1: After reset, every FIFO is empty, every channel is disabled with read position 0 and loss count 0, the interrupt mask is 0, `irq_o` is 0 and `rdata_o` is 0.
- R2: The register map uses byte addresses. Global registers: interrupt status at 0x00, interrupt mask at 0x04, buffer status at 0x08. Port p (0-based) occupies a block at 0x20 + 0x20*p, holding transmit status at +0x00, receive status at +0x04, transmit data at +0x08 and receive data at +0x0C. `rdata_o` shows the read result in the cycle after `rd_en_i`, and is 0 in every other cycle and for unmapped addresses.
- R3: A status word has the enable at bit 15, the 5-bit read position at bits 12:8 and the 4-bit loss count at bits 7:4; all other bits read 0. A write to a status register sets the enable from bit 15 of `wdata_i`.
- R4: A capture is queued only while its channel is enabled. A capture on a disabled channel is neither queued nor counted as lost.
- R5: A record is delivered as 12 words in this order: tag, seconds (3 words, most significant first), nanoseconds (2 words, most significant first), clock identity (4 words, most significant first), port number, sequence number. The 192-bit capture input carries word 0 in bits 191:176 and word 11 in bits 15:0.
- R6: Each data read of a non-empty FIFO advances the read position by one. The read that returns word 11 resets the position to 0 and removes the record, so the next read starts the next record in arrival order.
- R7: A data read while the FIFO is empty returns 0 and leaves the read position unchanged.
- R8: A capture on an enabled channel whose FIFO is full is dropped and adds one to the loss count, which stops at 15. A status read returns the count and clears it; a drop in the same cycle as that read leaves the count at 1.
- R9: The buffer status has one not-empty bit per channel: transmit of port p at bit p, receive of port p at bit NUM_PORTS+p.
- R10: The interrupt status reads the same not-empty bits as the buffer status. The mask register uses the same layout, and a 1 enables that channel. `irq_o` is 1 exactly when a not-empty channel has its mask bit set. The mask changes only on a write.
- R11: The channels are independent: captures, reads and enables on one channel leave every other channel's FIFO and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_cap_valid_i | input | NUM_PORTS | Transmit capture strobe, one per port |
| tx_cap_rec_i | input | NUM_PORTS*192 | Transmit capture records, port p in slice p |
| rx_cap_valid_i | input | NUM_PORTS | Receive capture strobe, one per port |
| rx_cap_rec_i | input | NUM_PORTS*192 | Receive capture records, port p in slice p |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt: any unmasked non-empty channel |

## Verification
The checker watches several properties on every cycle:

- read data stays zero outside the cycle after a read strobe;
- a channel's not-empty flag rises only after a capture on that channel;
- the flag falls only after a register read;
- the mask holds its value when there is no write;
- the interrupt never fires when no channel holds data or when the mask is clear.

Other behaviour only the directed scenarios can show. This covers the exact word order of a record and the read position after a partial drain. It also covers the loss count: its increment, saturation, clear-on-read and same-cycle clear. Finally it covers disabled captures being ignored, empty reads, and independence between channels.

// File: rtl/ts_readout_pkg.sv
package ts_readout_pkg;
    localparam int WORD_W    = 16;
    localparam int REC_WORDS = 12;
    localparam int REC_W     = WORD_W * REC_WORDS;
    localparam int POS_W     = 5;
    localparam int DROP_W    = 4;
    localparam int OFF_W     = 5;

    // offsets inside a port block
    localparam logic [OFF_W-1:0] OFF_TX_STAT = 5'h00;
    localparam logic [OFF_W-1:0] OFF_RX_STAT = 5'h04;
    localparam logic [OFF_W-1:0] OFF_TX_DATA = 5'h08;
    localparam logic [OFF_W-1:0] OFF_RX_DATA = 5'h0C;
    // offsets inside the global block
    localparam logic [OFF_W-1:0] OFF_G_ISTAT = 5'h00;
    localparam logic [OFF_W-1:0] OFF_G_MASK  = 5'h04;
    localparam logic [OFF_W-1:0] OFF_G_BUF   = 5'h08;

    typedef struct packed {
        logic              en;
        logic [POS_W-1:0]  pos;
        logic [DROP_W-1:0] drops;
    } chan_state_t;
endpackage

// File: rtl/ts_rec_fifo.sv
module ts_rec_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 192
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic [DW-1:0] head_o,
    output logic          empty_o,
    output logic          full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_ptr_t;

    fifo_ptr_t ptr_d, ptr_q;
    logic [DW-1:0] store_q [DEPTH];

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + PTR_W'(1);
    endfunction

    always_comb begin
        ptr_d = ptr_q;
        if (push_i) ptr_d.wr = next_ptr(ptr_q.wr);
        if (pop_i)  ptr_d.rd = next_ptr(ptr_q.rd);
        ptr_d.cnt = ptr_q.cnt + CNT_W'(push_i) - CNT_W'(pop_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ptr_q <= '0;
        else         ptr_q <= ptr_d;
    end

    always_ff @(posedge clk_i) begin
        if (push_i) store_q[ptr_q.wr] <= push_data_i;
    end

    assign head_o  = store_q[ptr_q.rd];
    assign empty_o = (ptr_q.cnt == '0);
    assign full_o  = (ptr_q.cnt == CNT_W'(DEPTH));
endmodule

// File: rtl/ts_chan.sv
module ts_chan
    import ts_readout_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cap_valid_i,
    input  logic [REC_W-1:0]  cap_rec_i,
    input  logic              stat_rd_i,
    input  logic              stat_wr_i,
    input  logic              en_wdata_i,
    input  logic              data_rd_i,
    output logic [WORD_W-1:0] stat_o,
    output logic [WORD_W-1:0] data_o,
    output logic              not_empty_o
);
    localparam logic [POS_W-1:0]  LAST_POS = POS_W'(REC_WORDS - 1);
    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    chan_state_t st_d, st_q;
    logic push, pop, drop, empty, full;
    logic [REC_W-1:0] head, shifted;

    ts_rec_fifo #(.DEPTH(DEPTH), .DW(REC_W)) u_fifo (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .push_i     (push),
        .push_data_i(cap_rec_i),
        .pop_i      (pop),
        .head_o     (head),
        .empty_o    (empty),
        .full_o     (full)
    );

    always_comb begin
        st_d = st_q;
        push = cap_valid_i && st_q.en && !full;
        drop = cap_valid_i && st_q.en && full;
        pop  = 1'b0;
        if (stat_wr_i) st_d.en = en_wdata_i;
        if (stat_rd_i) st_d.drops = '0;
        if (drop && st_d.drops != DROP_MAX) st_d.drops = st_d.drops + 1'b1;
        if (data_rd_i && !empty) begin
            if (st_q.pos == LAST_POS) begin
                st_d.pos = '0;
                pop      = 1'b1;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // word k of the record sits at the top, shifted down by its index
    always_comb begin
        shifted = head >> ((REC_WORDS - 1 - int'(st_q.pos)) * WORD_W);
        data_o  = empty ? '0 : shifted[WORD_W-1:0];
    end

    assign stat_o      = {st_q.en, 2'b00, st_q.pos, st_q.drops, 4'b0000};
    assign not_empty_o = !empty;
endmodule

// File: rtl/ts_addr_dec.sv
module ts_addr_dec
    import ts_readout_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int ADDR_W    = 8
) (
    input  logic                   rd_en_i,
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      addr_i,
    output logic [2*NUM_PORTS-1:0] stat_rd_o,
    output logic [2*NUM_PORTS-1:0] stat_wr_o,
    output logic [2*NUM_PORTS-1:0] data_rd_o,
    output logic                   istat_rd_o,
    output logic                   mask_rd_o,
    output logic                   mask_wr_o,
    output logic                   buf_rd_o
);
    localparam int BLK_W = ADDR_W - OFF_W;

    logic [BLK_W-1:0] blk;
    logic [OFF_W-1:0] off;
    logic             glb;

    assign blk = addr_i[ADDR_W-1:OFF_W];
    assign off = addr_i[OFF_W-1:0];
    assign glb = (blk == '0);

    assign istat_rd_o = rd_en_i && glb && (off == OFF_G_ISTAT);
    assign mask_rd_o  = rd_en_i && glb && (off == OFF_G_MASK);
    assign mask_wr_o  = wr_en_i && glb && (off == OFF_G_MASK);
    assign buf_rd_o   = rd_en_i && glb && (off == OFF_G_BUF);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic hit;
        assign hit = (blk == BLK_W'(p + 1));
        assign stat_rd_o[p]           = rd_en_i && hit && (off == OFF_TX_STAT);
        assign stat_rd_o[NUM_PORTS+p] = rd_en_i && hit && (off == OFF_RX_STAT);
        assign stat_wr_o[p]           = wr_en_i && hit && (off == OFF_TX_STAT);
        assign stat_wr_o[NUM_PORTS+p] = wr_en_i && hit && (off == OFF_RX_STAT);
        assign data_rd_o[p]           = rd_en_i && hit && (off == OFF_TX_DATA);
        assign data_rd_o[NUM_PORTS+p] = rd_en_i && hit && (off == OFF_RX_DATA);
    end
endmodule

// File: rtl/ts_capture_readout.sv
module ts_capture_readout
    import ts_readout_pkg::*;
#(
    parameter int NUM_PORTS  = 3,
    parameter int FIFO_DEPTH = 4,
    parameter int ADDR_W     = 8
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [NUM_PORTS-1:0]         tx_cap_valid_i,
    input  logic [NUM_PORTS*REC_W-1:0]   tx_cap_rec_i,
    input  logic [NUM_PORTS-1:0]         rx_cap_valid_i,
    input  logic [NUM_PORTS*REC_W-1:0]   rx_cap_rec_i,
    input  logic                         rd_en_i,
    input  logic                         wr_en_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [WORD_W-1:0]            wdata_i,
    output logic [WORD_W-1:0]            rdata_o,
    output logic                         irq_o
);
    localparam int NCH = 2 * NUM_PORTS;

    typedef struct packed {
        logic [NCH-1:0]    mask;
        logic [WORD_W-1:0] rdata;
    } top_state_t;

    top_state_t top_d, top_q;

    logic [NCH-1:0]       cap_valid;
    logic [NCH*REC_W-1:0] cap_rec;
    logic [NCH-1:0]       stat_rd, stat_wr, data_rd, nonempty;
    logic                 istat_rd, mask_rd, mask_wr, buf_rd;
    logic [WORD_W-1:0]    stat_word [NCH];
    logic [WORD_W-1:0]    data_word [NCH];
    logic [NCH-1:0]       mask_q;

    assign cap_valid = {rx_cap_valid_i, tx_cap_valid_i};
    assign cap_rec   = {rx_cap_rec_i, tx_cap_rec_i};

    ts_addr_dec #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_dec (
        .rd_en_i   (rd_en_i),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .stat_rd_o (stat_rd),
        .stat_wr_o (stat_wr),
        .data_rd_o (data_rd),
        .istat_rd_o(istat_rd),
        .mask_rd_o (mask_rd),
        .mask_wr_o (mask_wr),
        .buf_rd_o  (buf_rd)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        ts_chan #(.DEPTH(FIFO_DEPTH)) u_chan (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .cap_valid_i(cap_valid[c]),
            .cap_rec_i  (cap_rec[c*REC_W +: REC_W]),
            .stat_rd_i  (stat_rd[c]),
            .stat_wr_i  (stat_wr[c]),
            .en_wdata_i (wdata_i[WORD_W-1]),
            .data_rd_i  (data_rd[c]),
            .stat_o     (stat_word[c]),
            .data_o     (data_word[c]),
            .not_empty_o(nonempty[c])
        );
    end

    always_comb begin
        logic [WORD_W-1:0] acc;
        top_d = top_q;
        acc   = '0;
        if (mask_wr) top_d.mask = wdata_i[NCH-1:0];
        for (int c = 0; c < NCH; c++) begin
            if (stat_rd[c]) acc = acc | stat_word[c];
            if (data_rd[c]) acc = acc | data_word[c];
        end
        if (istat_rd || buf_rd) acc = acc | WORD_W'(nonempty);
        if (mask_rd)            acc = acc | WORD_W'(top_q.mask);
        top_d.rdata = acc;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) top_q <= '0;
        else         top_q <= top_d;
    end

    assign mask_q  = top_q.mask;
    assign rdata_o = top_q.rdata;
    assign irq_o   = |(nonempty & top_q.mask);
endmodule

// File: rtl/ts_readout_chk.sv
module ts_readout_chk #(
    parameter int NCH = 6
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           rd_en_i,
    input logic           wr_en_i,
    input logic [NCH-1:0] cap_valid,
    input logic [NCH-1:0] nonempty,
    input logic [NCH-1:0] mask_q,
    input logic [15:0]    rdata_o,
    input logic           irq_o
);
    // R2
    idle_rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> rdata_o == 16'h0000);

    // R10
    irq_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> nonempty != '0);

    // R10
    irq_masked_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mask_q == '0 |-> !irq_o);

    // R10
    mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(mask_q));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // R4
        fill_needs_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(nonempty[c]) |-> $past(cap_valid[c]));

        // R6
        drain_needs_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(nonempty[c]) |-> $past(rd_en_i));
    end
endmodule

bind ts_capture_readout ts_readout_chk #(.NCH(2*NUM_PORTS)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en_i),
    .wr_en_i  (wr_en_i),
    .cap_valid(cap_valid),
    .nonempty (nonempty),
    .mask_q   (mask_q),
    .rdata_o  (rdata_o),
    .irq_o    (irq_o)
);

// File: tb/test_ts_capture_readout.sv
module test_ts_capture_readout;
    localparam int NP = 3;
    localparam int RW = 192;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0]    tx_v = '0, rx_v = '0;
    logic [NP*RW-1:0] tx_r = '0, rx_r = '0;
    logic          rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic          irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ts_capture_readout #(.NUM_PORTS(NP), .FIFO_DEPTH(4), .ADDR_W(8)) i_ts_capture_readout (
        .clk_i(clk), .rst_ni(rst_n),
        .tx_cap_valid_i(tx_v), .tx_cap_rec_i(tx_r),
        .rx_cap_valid_i(rx_v), .rx_cap_rec_i(rx_r),
        .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [RW-1:0] mk_rec(input logic [7:0] s);
        logic [RW-1:0] r;
        for (int k = 0; k < 12; k++) r[RW-1-16*k -: 16] = {s, 8'(k)};
        return r;
    endfunction

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic cap(input bit is_rx, input int p, input logic [7:0] s);
        @(negedge clk);
        if (is_rx) begin rx_v[p] = 1'b1; rx_r[p*RW +: RW] = mk_rec(s); end
        else       begin tx_v[p] = 1'b1; tx_r[p*RW +: RW] = mk_rec(s); end
        @(negedge clk); tx_v = '0; rx_v = '0;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        chk("R1 irq", {15'd0, irq}, 16'h0000);
        chk("R1 rdata", rdata, 16'h0000);
        rd(8'h20, d); chk("R1 tx0 status", d, 16'h0000);
        rd(8'h08, d); chk("R1 buffer status", d, 16'h0000);
        rd(8'h04, d); chk("R1 mask", d, 16'h0000);
        rd(8'h1C, d); chk("R2 unmapped read", d, 16'h0000);
    endtask

    task automatic t_disabled;
        logic [15:0] d;
        cap(1'b0, 0, 8'h77);
        rd(8'h08, d); chk("R4 disabled not queued", d, 16'h0000);
        rd(8'h20, d); chk("R4 disabled not counted", d, 16'h0000);
    endtask

    task automatic t_enable;
        logic [15:0] d;
        wr(8'h20, 16'h8000);
        rd(8'h20, d); chk("R3 enable bit", d, 16'h8000);
    endtask

    task automatic t_serial;
        logic [15:0] d;
        cap(1'b0, 0, 8'hA5);
        rd(8'h08, d); chk("R9 tx0 bit", d, 16'h0001);
        for (int k = 0; k < 5; k++) begin
            rd(8'h28, d); chk("R5 word order", d, {8'hA5, 8'(k)});
        end
        rd(8'h20, d); chk("R6 read position", d, 16'h8500);
        for (int k = 5; k < 12; k++) begin
            rd(8'h28, d); chk("R5 word order", d, {8'hA5, 8'(k)});
        end
        rd(8'h20, d); chk("R6 position wraps", d, 16'h8000);
        rd(8'h08, d); chk("R6 record popped", d, 16'h0000);
    endtask

    task automatic t_empty;
        logic [15:0] d;
        rd(8'h28, d); chk("R7 empty read zero", d, 16'h0000);
        rd(8'h20, d); chk("R7 position unchanged", d, 16'h8000);
    endtask

    task automatic t_order;
        logic [15:0] d;
        cap(1'b0, 0, 8'h31);
        cap(1'b0, 0, 8'h32);
        for (int r = 0; r < 2; r++)
            for (int k = 0; k < 12; k++) begin
                rd(8'h28, d); chk("R6 arrival order", d, {8'(8'h31 + r), 8'(k)});
            end
        rd(8'h08, d); chk("R6 drained", d, 16'h0000);
    endtask

    task automatic t_overflow;
        logic [15:0] d;
        wr(8'h40, 16'h8000);
        for (int i = 0; i < 7; i++) cap(1'b0, 1, 8'(8'h10 + i));
        rd(8'h40, d); chk("R8 loss count", d, 16'h8030);
        rd(8'h40, d); chk("R8 clear on read", d, 16'h8000);
        for (int i = 0; i < 20; i++) cap(1'b0, 1, 8'hEE);
        // status read and a drop in the same cycle
        @(negedge clk);
        rd_en = 1'b1; addr = 8'h40; tx_v[1] = 1'b1; tx_r[RW +: RW] = mk_rec(8'hEF);
        @(negedge clk);
        rd_en = 1'b0; tx_v = '0; d = rdata;
        chk("R8 saturates at 15", d, 16'h80F0);
        rd(8'h40, d); chk("R8 same-cycle drop leaves 1", d, 16'h8010);
        rd(8'h20, d); chk("R11 tx0 status untouched", d, 16'h8000);
        for (int r = 0; r < 4; r++)
            for (int k = 0; k < 12; k++) begin
                rd(8'h48, d);
                if (k == 0 || k == 11) chk("R8 kept records", d, {8'(8'h10 + r), 8'(k)});
            end
        rd(8'h08, d); chk("R9 tx1 empty", d, 16'h0000);
    endtask

    task automatic t_rx_irq;
        logic [15:0] d;
        wr(8'h64, 16'h8000);
        cap(1'b1, 2, 8'h5C);
        rd(8'h08, d); chk("R9 rx2 bit", d, 16'h0020);
        rd(8'h60, d); chk("R11 tx2 status independent", d, 16'h0000);
        rd(8'h6C, d); chk("R5 rx tag word", d, 16'h5C00);
        chk("R10 irq masked", {15'd0, irq}, 16'h0000);
        wr(8'h04, 16'h0020);
        chk("R10 irq raised", {15'd0, irq}, 16'h0001);
        rd(8'h00, d); chk("R10 interrupt status", d, 16'h0020);
        rd(8'h04, d); chk("R10 mask readback", d, 16'h0020);
        wr(8'h04, 16'h0001);
        chk("R10 irq other mask", {15'd0, irq}, 16'h0000);
        for (int k = 1; k < 12; k++) begin
            rd(8'h6C, d); chk("R5 rx words", d, {8'h5C, 8'(k)});
        end
        rd(8'h08, d); chk("R9 rx2 drained", d, 16'h0000);
        wr(8'h20, 16'h0000);
        cap(1'b0, 0, 8'h99);
        rd(8'h08, d); chk("R4 disabled again", d, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_disabled;
        t_enable;
        t_serial;
        t_empty;
        t_order;
        t_overflow;
        t_rx_irq;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule